// File: doc/BRIEF.md
# CAN Message Slot Flag Register

This block keeps the control and status flags of a single message slot in a CAN controller. It holds five flags: a direction bit, a transmit-inhibit bit, a pending transmit-request flag, a data-updated flag and a receive-overwrite flag. A CPU register port reads and writes these flags. Event strobes from the protocol engine also change them: a message was stored in the slot, a remote frame addressed the slot, or the slot's transmission completed.

The flags depend on each other. When the CPU clears the data-updated flag, the overwrite flag clears with it. A remote frame that arrives while transmission is inhibited stays pending, and the reply goes out once the CPU lifts the inhibit. The inhibit bit can only be changed while the slot is set to transmit. The block drives a transmit-permitted level to the protocol engine and a one-cycle receive interrupt pulse. Bit timing, arbitration and the message data buffer belong to other blocks.

Top module: `can_slot_flags`

## Requirements
- R1: After a synchronous active-low reset, all flags are 0: direction = receive (0), `cpu_rdata` = 0, `tx_permit` = 0 and `irq` = 0.
- R2: Register field positions are direction bit 0 (1 = transmit), inhibit bit 1, request bit 2, data-updated bit 3 and overwrite bit 4 (read-only). All higher read bits are 0. While the direction is receive, a store event sets data-updated. While the direction is transmit, a store event has no effect.
- R3: Data-updated is cleared only by a CPU write of 0 to bit 3 or by `soft_rst`. A CPU write of 1 sets it. A store in the same cycle as a CPU clear leaves it at 1.
- R4: A store that finds data-updated already at 1 sets the overwrite flag when `ovw_en` = 1. It leaves the overwrite flag unchanged when `ovw_en` = 0.
- R5: A CPU write that clears data-updated also clears the overwrite flag, unless a store event happens in the same cycle.
- R6: `tx_permit` is 1 exactly when the direction is transmit, inhibit is 0 and the request flag is 1.
- R7: While the direction is transmit, a remote-frame event sets the request flag whatever the inhibit bit holds, so the reply waits until inhibit is cleared. While the direction is receive, a remote-frame event has no effect.
- R8: The request flag is cleared by `ev_tx_done` or by a CPU write of 0 to bit 2, and set by a CPU write of 1. Any set beats any clear in the same cycle.
- R9: A write to the inhibit bit takes effect only if the direction held before that write is transmit. The bit keeps its value across direction changes.
- R10: `irq` is high for the one cycle after a store event that is accepted while `rx_irq_en` = 1, and low otherwise.
- R11: While the direction is receive, inhibit is 1 and `ovw_en` = 1, the overwrite bit reads back as 1 whatever the stored overwrite flag holds.
- R12: `soft_rst` clears data-updated, overwrite, request and `irq`, and takes priority over every event. Direction and inhibit keep their values.
- R13: A CPU write changes only the fields whose bit in `cpu_wmask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Controller soft reset; clears the status flags |
| ovw_en | input | 1 | Overwrite of unread received data permitted |
| rx_irq_en | input | 1 | Receive interrupt enable |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wmask | input | 4 | Per-field write enable for bits 0..3 |
| cpu_wdata | input | 4 | CPU write data for bits 0..3 |
| cpu_rdata | output | CPU_W | Flag readback, zero-padded |
| ev_stored | input | 1 | Protocol engine stored a received message |
| ev_remote | input | 1 | Remote frame for this slot received |
| ev_tx_done | input | 1 | Slot message transmitted |
| tx_permit | output | 1 | Slot may be transmitted now |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The bench uses the default `CPU_W` = 8. At that width every field position is visible on the read port, and the three always-zero upper bits are checked in the same comparison. Each field has one bit, so the parameter does not limit which flag couplings can be reached. All same-cycle collisions are driven: a store against a CPU clear, a remote frame against a completion or a request clear, and a soft reset against a store. The inhibit-readback anomaly is also driven after the direction changes.

// File: rtl/can_slot_pkg.sv
// Package: field positions and widths shared by the slot flag logic.
// Assumes one bit per field; the overwrite flag is read-only and sits above
// the writable fields.
package can_slot_pkg;
    localparam int NUM_WR = 4;          // writable fields
    localparam int NUM_FIELDS = 5;      // readable fields
    localparam int B_DIR = 0;           // 1 = transmit
    localparam int B_INH = 1;
    localparam int B_REQ = 2;
    localparam int B_UPD = 3;
    localparam int B_OVR = 4;
endpackage

// File: rtl/slot_rx_flags.sv
// Receive-side flags: data-updated, overwrite and the interrupt pulse.
// Assumes store events are single-cycle strobes and that store_ok already
// includes the direction check. Hardware sets beat CPU clears;
// soft reset beats everything.
module slot_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic store_ok,
    input  logic ovw_en,
    input  logic rx_irq_en,
    input  logic upd_we,
    input  logic upd_wd,
    output logic upd,
    output logic ovr,
    output logic irq
);
    logic cpu_clr, cpu_set, ovr_set;

    // Decode the CPU write and the overwrite condition.
    always_comb begin
        cpu_clr = upd_we && !upd_wd;
        cpu_set = upd_we && upd_wd;
        ovr_set = store_ok && upd && ovw_en;
    end

    // Data-updated flag: set by a store or CPU write-1, cleared only by a CPU write-0.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)        upd <= 1'b0;
        else if (store_ok || cpu_set)  upd <= 1'b1;
        else if (cpu_clr)              upd <= 1'b0;
    end

    // Overwrite flag: set on a store over unread data, cleared along with data-updated.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)  ovr <= 1'b0;
        else if (ovr_set)        ovr <= 1'b1;
        else if (cpu_clr)        ovr <= 1'b0;
    end

    // Interrupt: one-cycle pulse after an accepted store.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)  irq <= 1'b0;
        else                     irq <= store_ok && rx_irq_en;
    end
endmodule

// File: rtl/slot_tx_flags.sv
// Transmit-side flags: inhibit, pending request and the permit level.
// Assumes tx_dir reflects the direction before the current write. Any request
// set beats any clear in the same cycle.
module slot_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tx_dir,
    input  logic ev_remote,
    input  logic ev_tx_done,
    input  logic inh_we,
    input  logic inh_wd,
    input  logic req_we,
    input  logic req_wd,
    output logic inh,
    output logic req,
    output logic tx_permit
);
    logic req_set, req_clr;

    // Collect the set and clear sources of the request flag.
    always_comb begin
        req_set = (ev_remote && tx_dir) || (req_we && req_wd);
        req_clr = ev_tx_done || (req_we && !req_wd);
    end

    // Inhibit: CPU-writable only in transmit direction; soft reset leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)                 inh <= 1'b0;
        else if (inh_we && tx_dir)  inh <= inh_wd;
    end

    // Pending request: a remote frame or CPU set; served or dropped by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)  req <= 1'b0;
        else if (req_set)        req <= 1'b1;
        else if (req_clr)        req <= 1'b0;
    end

    // Permit: transmit direction, not inhibited and something to send.
    always_comb tx_permit = tx_dir && !inh && req;
endmodule

// File: rtl/can_slot_flags.sv
// Top: flag register for one CAN message slot. It holds the direction bit,
// decodes masked CPU writes and builds the readback word, including the
// inhibit-related overwrite readback. Assumes CPU_W >= 5.
module can_slot_flags
    import can_slot_pkg::*;
#(
    parameter int CPU_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ovw_en,
    input  logic              rx_irq_en,
    input  logic              cpu_wr,
    input  logic [NUM_WR-1:0] cpu_wmask,
    input  logic [NUM_WR-1:0] cpu_wdata,
    output logic [CPU_W-1:0]  cpu_rdata,
    input  logic              ev_stored,
    input  logic              ev_remote,
    input  logic              ev_tx_done,
    output logic              tx_permit,
    output logic              irq
);
    localparam int PAD_W = CPU_W - NUM_FIELDS;

    logic [NUM_WR-1:0] we;
    logic dir_q, inh_q, req_q, upd_q, ovr_q, ovr_view;

    // Per-field write enables from the strobe and mask.
    always_comb we = cpu_wr ? cpu_wmask : '0;

    // Direction bit: plain CPU-writable field.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_q <= 1'b0;
        else if (we[B_DIR])  dir_q <= cpu_wdata[B_DIR];
    end

    slot_rx_flags u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .store_ok  (ev_stored && !dir_q),
        .ovw_en    (ovw_en),
        .rx_irq_en (rx_irq_en),
        .upd_we    (we[B_UPD]),
        .upd_wd    (cpu_wdata[B_UPD]),
        .upd       (upd_q),
        .ovr       (ovr_q),
        .irq       (irq)
    );

    slot_tx_flags u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .tx_dir     (dir_q),
        .ev_remote  (ev_remote),
        .ev_tx_done (ev_tx_done),
        .inh_we     (we[B_INH]),
        .inh_wd     (cpu_wdata[B_INH]),
        .req_we     (we[B_REQ]),
        .req_wd     (cpu_wdata[B_REQ]),
        .inh        (inh_q),
        .req        (req_q),
        .tx_permit  (tx_permit)
    );

    // Overwrite readback: a leftover inhibit in receive mode forces it high.
    always_comb ovr_view = ovr_q || (!dir_q && inh_q && ovw_en);

    // Readback word with zero padding above the fields.
    generate
        if (PAD_W > 0) begin : g_pad
            assign cpu_rdata = {{PAD_W{1'b0}}, ovr_view, upd_q, req_q, inh_q, dir_q};
        end else begin : g_nopad
            assign cpu_rdata = {ovr_view, upd_q, req_q, inh_q, dir_q};
        end
    endgenerate
endmodule

// File: rtl/can_slot_flags_chk.sv
// Checker: temporal properties of the slot flags, bound to the top module.
// Assumes the internal flag registers are connected through the bind.
module can_slot_flags_chk
    import can_slot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              rx_irq_en,
    input logic              cpu_wr,
    input logic [NUM_WR-1:0] cpu_wmask,
    input logic [NUM_WR-1:0] cpu_wdata,
    input logic              ev_stored,
    input logic              ev_remote,
    input logic              ev_tx_done,
    input logic              tx_permit,
    input logic              irq,
    input logic              dir,
    input logic              inh,
    input logic              req,
    input logic              upd,
    input logic              ovr
);
    logic cpu_upd_clr, cpu_req_set;
    always_comb begin
        cpu_upd_clr = cpu_wr && cpu_wmask[B_UPD] && !cpu_wdata[B_UPD];
        cpu_req_set = cpu_wr && cpu_wmask[B_REQ] && cpu_wdata[B_REQ];
    end

    p_store_sets_upd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stored && !dir && !soft_rst) |=> upd);

    p_upd_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !soft_rst && !cpu_upd_clr) |=> upd);

    p_ovr_follows_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_upd_clr && !ev_stored) |=> !ovr);

    p_inhibit_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inh |-> !tx_permit);

    p_remote_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_remote && dir && !soft_rst) |=> req);

    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_done && !ev_remote && !cpu_req_set && !soft_rst) |=> !req);

    p_inh_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |=> $stable(inh));

    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stored && !dir && rx_irq_en && !soft_rst) |=> irq);

    p_soft_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!upd && !ovr && !req && !irq));
endmodule

bind can_slot_flags can_slot_flags_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rx_irq_en  (rx_irq_en),
    .cpu_wr     (cpu_wr),
    .cpu_wmask  (cpu_wmask),
    .cpu_wdata  (cpu_wdata),
    .ev_stored  (ev_stored),
    .ev_remote  (ev_remote),
    .ev_tx_done (ev_tx_done),
    .tx_permit  (tx_permit),
    .irq        (irq),
    .dir        (dir_q),
    .inh        (inh_q),
    .req        (req_q),
    .upd        (upd_q),
    .ovr        (ovr_q)
);

// File: tb/sim_can_slot_flags.sv
// Directed bench for the slot flag register: one task per scenario.
module sim_can_slot_flags;
    localparam int DIR = 0, INH = 1, REQ = 2, UPD = 3, OVR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0, ovw_en = 1'b0, rx_irq_en = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [3:0] cpu_wmask = '0, cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ev_stored = 1'b0, ev_remote = 1'b0, ev_tx_done = 1'b0;
    logic       tx_permit, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    can_slot_flags #(.CPU_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ovw_en(ovw_en),
        .rx_irq_en(rx_irq_en), .cpu_wr(cpu_wr), .cpu_wmask(cpu_wmask),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ev_stored(ev_stored),
        .ev_remote(ev_remote), .ev_tx_done(ev_tx_done), .tx_permit(tx_permit),
        .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock with the given strobes; starts and ends at a falling edge.
    task automatic step(input logic st, input logic rm, input logic dn, input logic sr,
                        input logic wr, input logic [3:0] m, input logic [3:0] d);
        ev_stored = st; ev_remote = rm; ev_tx_done = dn; soft_rst = sr;
        cpu_wr = wr; cpu_wmask = m; cpu_wdata = d;
        @(negedge clk);
        ev_stored = 0; ev_remote = 0; ev_tx_done = 0; soft_rst = 0;
        cpu_wr = 0; cpu_wmask = '0; cpu_wdata = '0;
    endtask

    task automatic wr(input logic [3:0] m, input logic [3:0] d);
        step(0, 0, 0, 0, 1, m, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; ovw_en = 0; rx_irq_en = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rdata", cpu_rdata, 8'h00);
        chk("R1 permit", {7'b0, tx_permit}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_rx_store();
        do_reset(); ovw_en = 1; rx_irq_en = 1;
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        chk("R2 store sets upd", cpu_rdata, 8'h08);
        chk("R10 irq pulse", {7'b0, irq}, 8'h01);
        step(0, 0, 0, 0, 0, 4'h0, 4'h0);
        chk("R10 irq one cycle", {7'b0, irq}, 8'h00);
        chk("R3 upd held", cpu_rdata, 8'h08);
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        chk("R4 overwrite set", cpu_rdata, 8'h18);
        wr(4'b1000, 4'b0000);
        chk("R5 clear upd clears ovr", cpu_rdata, 8'h00);
    endtask

    task automatic t_rx_no_ovw();
        do_reset(); ovw_en = 0; rx_irq_en = 0;
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        chk("R10 no irq when disabled", {7'b0, irq}, 8'h00);
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        chk("R4 no overwrite when ovw_en=0", cpu_rdata, 8'h08);
    endtask

    task automatic t_set_wins();
        do_reset(); ovw_en = 1;
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        step(1, 0, 0, 0, 1, 4'b1000, 4'b0000);
        chk("R3 store beats cpu clear", cpu_rdata, 8'h18);
        wr(4'b1000, 4'b0000);
        chk("R5 clear both", cpu_rdata, 8'h00);
        wr(4'b1000, 4'b1000);
        chk("R3 cpu sets upd", cpu_rdata, 8'h08);
    endtask

    task automatic t_tx_ignores_store();
        do_reset(); rx_irq_en = 1;
        wr(4'b0001, 4'b0001);
        chk("R2 dir field", cpu_rdata, 8'h01);
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        chk("R2 store ignored in transmit", cpu_rdata, 8'h01);
        chk("R10 no irq in transmit", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_tx_defer();
        do_reset();
        wr(4'b0001, 4'b0001);
        wr(4'b0010, 4'b0010);
        chk("R9 inh written in transmit", cpu_rdata, 8'h03);
        step(0, 1, 0, 0, 0, 4'h0, 4'h0);
        chk("R7 remote latched while inhibited", cpu_rdata, 8'h07);
        chk("R6 no permit while inhibited", {7'b0, tx_permit}, 8'h00);
        wr(4'b0010, 4'b0000);
        chk("R6 permit after inhibit cleared", {7'b0, tx_permit}, 8'h01);
        step(0, 0, 1, 0, 0, 4'h0, 4'h0);
        chk("R8 done clears req", cpu_rdata, 8'h01);
        chk("R6 no permit without req", {7'b0, tx_permit}, 8'h00);
        wr(4'b0100, 4'b0100);
        chk("R8 cpu sets req", {7'b0, tx_permit}, 8'h01);
        step(0, 1, 1, 0, 0, 4'h0, 4'h0);
        chk("R8 remote beats done", cpu_rdata, 8'h05);
        step(0, 1, 0, 0, 1, 4'b0100, 4'b0000);
        chk("R8 remote beats cpu clear", cpu_rdata, 8'h05);
        wr(4'b0100, 4'b0000);
        chk("R8 cpu clears req", cpu_rdata, 8'h01);
    endtask

    task automatic t_inh_lock();
        do_reset();
        wr(4'b0011, 4'b0011);
        chk("R9 inh blocked by prior receive dir", cpu_rdata, 8'h01);
        wr(4'b0010, 4'b0010);
        wr(4'b0001, 4'b0000);
        ovw_en = 1;
        #1;
        chk("R11 forced overwrite readback", cpu_rdata, 8'h12);
        ovw_en = 0;
        #1;
        chk("R11 no forcing with ovw_en=0", cpu_rdata, 8'h02);
        wr(4'b0010, 4'b0000);
        chk("R9 inh write ignored in receive", cpu_rdata, 8'h02);
        step(0, 1, 0, 0, 0, 4'h0, 4'h0);
        chk("R7 remote ignored in receive", cpu_rdata, 8'h02);
        wr(4'b0011, 4'b0001);
        chk("R9 gate uses old dir", cpu_rdata, 8'h03);
        wr(4'b0010, 4'b0000);
        chk("R9 inh cleared in transmit", cpu_rdata, 8'h01);
    endtask

    task automatic t_soft();
        do_reset(); rx_irq_en = 1;
        wr(4'b0001, 4'b0001);
        wr(4'b0010, 4'b0010);
        wr(4'b0001, 4'b0000);
        wr(4'b0100, 4'b0100);
        chk("R6 no permit in receive", {7'b0, tx_permit}, 8'h00);
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        ovw_en = 1;
        step(1, 0, 0, 0, 0, 4'h0, 4'h0);
        ovw_en = 0;
        #1;
        chk("R4 ovr before soft reset", cpu_rdata, 8'h1E);
        step(1, 0, 0, 1, 0, 4'h0, 4'h0);
        chk("R12 soft reset clears status", cpu_rdata, 8'h02);
        chk("R12 soft reset clears irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_mask();
        do_reset();
        wr(4'b0001, 4'b0001);
        wr(4'b0010, 4'b0010);
        wr(4'b0000, 4'b1111);
        chk("R13 empty mask writes nothing", cpu_rdata, 8'h03);
        wr(4'b0100, 4'b1111);
        chk("R13 only masked field written", cpu_rdata, 8'h07);
    endtask

    initial begin
        t_reset();
        t_rx_store();
        t_rx_no_ovw();
        t_set_wins();
        t_tx_ignores_store();
        t_tx_defer();
        t_inh_lock();
        t_soft();
        t_mask();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule